// File: doc/BRIEF.md
# Custom Instruction Coprocessor

This block sits beside a 32-bit RISC-V execute stage and carries out user-defined instructions taken from the four custom opcode slots. The pipeline presents the full instruction word, a one-cycle start strobe and up to four 32-bit register operands. The block sorts the instruction into a three-, four- or five-register format by its opcode. It then runs the selected operation and answers with a 32-bit result and a `done_o` pulse.

Simple operations answer in the start cycle. The multiply-add answers two cycles later. A small command register, loaded by a three-register instruction, selects what the two immediate-free five-register instructions compute. An operation that never produces `done_o` is cut off after a parameterised number of cycles, and `illegal_o` then pulses so that the pipeline can raise an illegal-instruction exception. Codes that are not implemented, and the reserved command setting, use this path on purpose.

Top module: `cfx_unit`

## Requirements
- R1: After reset `done_o` and `illegal_o` are low, and the command register holds 0, so that a read returns 0 and variant A computes an AND.
- R2: A three-register instruction (opcode 0001011, bits [31:25] zero, bits [14:12]=0) returns `~(rs1 ^ rs2)` with `done_o` high in the start cycle.
- R3: With bits [31:25] zero, bits [14:12]=1 load rs1[3:0] into the command register and return 0. Bits [14:12]=2 return the command register zero-extended. Both finish in the start cycle.
- R4: Variant A (opcode 1011011) combines rs1..rs4 in the start cycle using command bits [1:0]: 0 is AND, 1 is OR, 2 is XOR.
- R5: Variant B (opcode 1111011) does the same using command bits [3:2], with the same encoding.
- R6: A five-register instruction whose command field is 3 never asserts `done_o` and ends in the timeout path.
- R7: A four-register instruction (opcode 0101011, bits [14:12]=0) returns the low 32 bits of rs1*rs2+rs3. `done_o` is high exactly two cycles after the start cycle. Instruction bits [26:25] have no effect.
- R8: While an operation is outstanding (from the cycle after its start up to and including its `done_o` or `illegal_o` cycle), `start_i` is ignored.
- R9: Any other code (three-register with nonzero bits [31:25] or bits [14:12] above 2, four-register with bits [14:12] nonzero, or a non-custom opcode) gives no `done_o`. `illegal_o` pulses for one cycle exactly `TMO_CYCLES` cycles after the start cycle, and a start is accepted again in the next cycle.
- R10: `done_o` and `illegal_o` are never high together, and `res_o` is 0 whenever `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request strobe; instruction and operands are valid with it |
| insn_i | input | 32 | Instruction word |
| rs1_i | input | 32 | First operand |
| rs2_i | input | 32 | Second operand |
| rs3_i | input | 32 | Third operand |
| rs4_i | input | 32 | Fourth operand |
| res_o | output | 32 | Result, valid while `done_o` is high |
| done_o | output | 1 | Completion pulse |
| illegal_o | output | 1 | Timeout pulse requesting an illegal-instruction exception |

## Verification
The assertions assume that the instruction and operands matter only in the cycle that `start_i` is high. They also assume that the pipeline may raise `start_i` at any time, including while the block is busy. The stimulus therefore changes operands to new values in every cycle and fires extra starts during multiply-add and timeout windows. With these changes, any reliance on held operands or on a quiet pipeline shows up as a mismatch. Inputs change only on the falling clock edge, so the start-cycle results seen by the assertions do not depend on process order.

// File: rtl/cfx_pkg.sv
package cfx_pkg;
    localparam int XLEN   = 32;
    localparam int MODE_W = 2;
    localparam int CMD_W  = 2 * MODE_W;

    localparam logic [6:0] OPC_R3  = 7'b0001011;
    localparam logic [6:0] OPC_R4  = 7'b0101011;
    localparam logic [6:0] OPC_R5A = 7'b1011011;
    localparam logic [6:0] OPC_R5B = 7'b1111011;

    typedef enum logic [2:0] {
        OP_NONE, OP_XNOR, OP_CMDW, OP_CMDR, OP_MACC, OP_R5A, OP_R5B
    } op_e;

    typedef struct packed {
        logic            ok;
        logic [XLEN-1:0] val;
    } res_t;

    function automatic op_e decode_op(input logic [31:0] insn);
        op_e op;
        op = OP_NONE;
        case (insn[6:0])
            OPC_R3: begin
                if (insn[31:25] == 7'd0) begin
                    case (insn[14:12])
                        3'd0:    op = OP_XNOR;
                        3'd1:    op = OP_CMDW;
                        3'd2:    op = OP_CMDR;
                        default: op = OP_NONE;
                    endcase
                end
            end
            OPC_R4:  op = (insn[14:12] == 3'd0) ? OP_MACC : OP_NONE;
            OPC_R5A: op = OP_R5A;
            OPC_R5B: op = OP_R5B;
            default: op = OP_NONE;
        endcase
        return op;
    endfunction

    function automatic res_t reduce4(input logic [MODE_W-1:0] mode,
                                     input logic [XLEN-1:0] a, b, c, d);
        res_t r;
        r.ok = 1'b1;
        case (mode)
            2'd0:    r.val = a & b & c & d;
            2'd1:    r.val = a | b | c | d;
            2'd2:    r.val = a ^ b ^ c ^ d;
            default: begin
                r.ok  = 1'b0;
                r.val = '0;
            end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/cfx_decode.sv
module cfx_decode
    import cfx_pkg::*;
(
    input  logic [31:0] insn_i,
    output op_e         op_o
);
    always_comb op_o = decode_op(insn_i);
endmodule

// File: rtl/cfx_alu.sv
module cfx_alu
    import cfx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            accept_i,
    input  op_e             op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [XLEN-1:0] c_i,
    input  logic [XLEN-1:0] d_i,
    output res_t            out_o
);
    logic [CMD_W-1:0] cmd_q;

    always_ff @(posedge clk) begin
        if (rst)                              cmd_q <= '0;
        else if (accept_i && op_i == OP_CMDW) cmd_q <= a_i[CMD_W-1:0];
    end

    always_comb begin
        out_o = '0;
        case (op_i)
            OP_XNOR: begin
                out_o.ok  = 1'b1;
                out_o.val = ~(a_i ^ b_i);
            end
            OP_CMDW: out_o.ok = 1'b1;
            OP_CMDR: begin
                out_o.ok  = 1'b1;
                out_o.val = {{(XLEN-CMD_W){1'b0}}, cmd_q};
            end
            OP_R5A:  out_o = reduce4(cmd_q[MODE_W-1:0], a_i, b_i, c_i, d_i);
            OP_R5B:  out_o = reduce4(cmd_q[CMD_W-1:MODE_W], a_i, b_i, c_i, d_i);
            default: out_o = '0;
        endcase
    end
endmodule

// File: rtl/cfx_macc.sv
module cfx_macc
    import cfx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            go_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [XLEN-1:0] c_i,
    output logic            done_o,
    output logic [XLEN-1:0] val_o
);
    logic            v1_q, v2_q;
    logic [XLEN-1:0] prod_q, add_q, sum_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q   <= 1'b0;
            v2_q   <= 1'b0;
            prod_q <= '0;
            add_q  <= '0;
            sum_q  <= '0;
        end else begin
            v1_q <= go_i;
            v2_q <= v1_q;
            if (go_i) begin
                prod_q <= a_i * b_i;
                add_q  <= c_i;
            end
            if (v1_q) sum_q <= prod_q + add_q;
        end
    end

    assign done_o = v2_q;
    assign val_o  = sum_q;
endmodule

// File: rtl/cfx_watch.sv
module cfx_watch #(
    parameter int TMO_CYCLES = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic launch_i,
    input  logic finish_i,
    output logic busy_o,
    output logic timeout_o
);
    localparam int CW = $clog2(TMO_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    assign timeout_o = busy_o && !finish_i && (cnt_q == CW'(TMO_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            cnt_q  <= '0;
        end else if (launch_i) begin
            busy_o <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_o && (finish_i || timeout_o)) begin
            busy_o <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_o) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cfx_unit.sv
module cfx_unit
    import cfx_pkg::*;
#(
    parameter int TMO_CYCLES = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [31:0] insn_i,
    input  logic [31:0] rs1_i,
    input  logic [31:0] rs2_i,
    input  logic [31:0] rs3_i,
    input  logic [31:0] rs4_i,
    output logic [31:0] res_o,
    output logic        done_o,
    output logic        illegal_o
);
    op_e             op;
    res_t            alu_out;
    logic            busy, accept, mac_done, timeout;
    logic [XLEN-1:0] mac_val;

    assign accept = start_i && !busy;

    cfx_decode u_dec (.insn_i(insn_i), .op_o(op));

    cfx_alu u_alu (
        .clk(clk), .rst(rst), .accept_i(accept), .op_i(op),
        .a_i(rs1_i), .b_i(rs2_i), .c_i(rs3_i), .d_i(rs4_i),
        .out_o(alu_out)
    );

    cfx_macc u_mac (
        .clk(clk), .rst(rst), .go_i(accept && op == OP_MACC),
        .a_i(rs1_i), .b_i(rs2_i), .c_i(rs3_i),
        .done_o(mac_done), .val_o(mac_val)
    );

    cfx_watch #(.TMO_CYCLES(TMO_CYCLES)) u_wd (
        .clk(clk), .rst(rst),
        .launch_i(accept && !alu_out.ok),
        .finish_i(mac_done),
        .busy_o(busy), .timeout_o(timeout)
    );

    always_comb begin
        done_o    = mac_done || (accept && alu_out.ok);
        illegal_o = timeout;
        if (mac_done)                 res_o = mac_val;
        else if (accept && alu_out.ok) res_o = alu_out.val;
        else                          res_o = '0;
    end
endmodule

// File: rtl/cfx_unit_chk.sv
module cfx_unit_chk
    import cfx_pkg::*;
#(
    parameter int TMO_CYCLES = 128
) (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic [31:0] insn_i,
    input logic [31:0] rs1_i,
    input logic [31:0] rs2_i,
    input logic [31:0] rs3_i,
    input logic [31:0] res_o,
    input logic        done_o,
    input logic        illegal_o,
    input logic        busy
);
    localparam int AW = $clog2(TMO_CYCLES + 2);

    logic [AW-1:0] age;

    always_ff @(posedge clk) begin
        if (rst)                                 age <= '0;
        else if (start_i && !busy && !done_o)    age <= AW'(1);
        else if (busy)                           age <= age + 1'b1;
        else                                     age <= '0;
    end

    assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(done_o && illegal_o));

    assert_idle_res_R10: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> res_o == 32'd0);

    assert_xnor_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy && insn_i[6:0] == OPC_R3 && insn_i[31:25] == 7'd0
         && insn_i[14:12] == 3'd0) |-> (done_o && res_o == ~(rs1_i ^ rs2_i)));

    assert_macc_R7: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy && insn_i[6:0] == OPC_R4 && insn_i[14:12] == 3'd0)
        |-> ##2 (done_o && res_o == $past(rs1_i, 2) * $past(rs2_i, 2) + $past(rs3_i, 2)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !done_o && !illegal_o) |=> busy);

    assert_window_R9: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (busy && age == AW'(TMO_CYCLES)));

    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        illegal_o |=> (!busy && !illegal_o));
endmodule

bind cfx_unit cfx_unit_chk #(.TMO_CYCLES(TMO_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .insn_i(insn_i),
    .rs1_i(rs1_i), .rs2_i(rs2_i), .rs3_i(rs3_i), .res_o(res_o),
    .done_o(done_o), .illegal_o(illegal_o), .busy(busy)
);

// File: tb/sim_cfx_unit.sv
module sim_cfx_unit;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] insn_i = '0, rs1_i = '0, rs2_i = '0, rs3_i = '0, rs4_i = '0;
    logic [31:0] res_o;
    logic        done_o, illegal_o;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    // reference model state
    bit          m_busy = 0;
    int          m_kind = 0;   // 1 multiply-add, 2 hang
    int          m_age  = 0;
    logic [31:0] m_macv = '0;
    logic [3:0]  m_cmd  = '0;

    cfx_unit #(.TMO_CYCLES(TMO)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .insn_i(insn_i),
        .rs1_i(rs1_i), .rs2_i(rs2_i), .rs3_i(rs3_i), .rs4_i(rs4_i),
        .res_o(res_o), .done_o(done_o), .illegal_o(illegal_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] red(input int mode, input logic [31:0] a, b, c, d, output bit ok);
        ok = 1;
        if (mode == 0) return a & b & c & d;
        if (mode == 1) return a | b | c | d;
        if (mode == 2) return a ^ b ^ c ^ d;
        ok = 0;
        return 0;
    endfunction

    // kind: 0 immediate answer, 1 multiply-add, 2 hang
    function automatic void ref_eval(input logic [31:0] ins, a, b, c, d, input logic [3:0] cmd,
                                     output int kind, output logic [31:0] val, output bit wcmd);
        int opc, f3;
        bit ok;
        opc  = int'(ins[6:0]);
        f3   = int'(ins[14:12]);
        kind = 2; val = 0; wcmd = 0;
        if (opc == 'h0B && ins[31:25] == 0) begin
            if (f3 == 0) begin kind = 0; val = ~(a ^ b); end
            else if (f3 == 1) begin kind = 0; wcmd = 1; end
            else if (f3 == 2) begin kind = 0; val = {28'd0, cmd}; end
        end else if (opc == 'h2B && f3 == 0) begin
            kind = 1; val = a * b + c;
        end else if (opc == 'h5B || opc == 'h7B) begin
            val = red(opc == 'h5B ? int'(cmd[1:0]) : int'(cmd[3:2]), a, b, c, d, ok);
            if (ok) kind = 0;
        end
    endfunction

    task automatic step(input bit st, input logic [31:0] ins, input string tag);
        bit          e_done, e_ill, wc;
        logic [31:0] e_res, v;
        int          k;
        @(negedge clk);
        start_i = st; insn_i = ins;
        rs1_i = $urandom; rs2_i = $urandom; rs3_i = $urandom; rs4_i = $urandom;
        #1;
        e_done = 0; e_ill = 0; e_res = 0;
        if (m_busy) begin
            if (m_kind == 1 && m_age == 2) begin e_done = 1; e_res = m_macv; end
            if (m_kind == 2 && m_age == TMO) e_ill = 1;
        end else if (st) begin
            ref_eval(ins, rs1_i, rs2_i, rs3_i, rs4_i, m_cmd, k, v, wc);
            if (k == 0) begin e_done = 1; e_res = v; if (wc) m_cmd = rs1_i[3:0]; end
            else begin m_busy = 1; m_kind = k; m_age = 0; m_macv = v; end
        end
        check(tag, done_o == e_done, 32'(done_o), 32'(e_done));
        check(tag, illegal_o == e_ill, 32'(illegal_o), 32'(e_ill));
        check(tag, res_o == e_res, res_o, e_res);
        check("R10", !(done_o && illegal_o), 32'(done_o & illegal_o), 0);
        if (m_busy) begin
            if (e_done || e_ill) m_busy = 0;
            else m_age++;
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 32'd0, tag);
    endtask

    function automatic logic [31:0] r3(input logic [6:0] f7, input logic [2:0] f3);
        return {f7, 5'd2, 5'd1, f3, 5'd3, 7'b0001011};
    endfunction
    function automatic logic [31:0] r4(input logic [2:0] f3, input logic [1:0] hi);
        return {5'd4, hi, 5'd2, 5'd1, f3, 5'd3, 7'b0101011};
    endfunction
    localparam logic [31:0] R5A = {5'd4, 2'd0, 5'd2, 5'd1, 3'd0, 5'd3, 7'b1011011};
    localparam logic [31:0] R5B = {5'd4, 2'd1, 5'd2, 5'd1, 3'd5, 5'd3, 7'b1111011};

    task automatic set_cmd(input logic [3:0] c, input string tag);
        @(negedge clk);
        start_i = 1; insn_i = r3(7'd0, 3'd1); rs1_i = {$urandom} & 32'hFFFF_FFF0 | {28'd0, c};
        #1;
        check(tag, done_o === 1'b1 && res_o == 0, res_o, 0);
        m_cmd = c;
        step(1, r3(7'd0, 3'd2), tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", done_o == 0 && illegal_o == 0, {30'd0, done_o, illegal_o}, 0);
        rst = 1'b0;
        // R1: command register starts at zero
        step(1, r3(7'd0, 3'd2), "R1");
        step(1, R5A, "R1");
        // R2: XNOR under several operand patterns
        for (int i = 0; i < 4; i++) step(1, r3(7'd0, 3'd0), "R2");
        // R3: load and read back the command register
        set_cmd(4'b1001, "R3");
        // R4 / R5: variant A OR, variant B XOR
        step(1, R5A, "R4");
        step(1, R5B, "R5");
        set_cmd(4'b0010, "R3");
        step(1, R5A, "R4");
        step(1, R5B, "R5");
        // R7: multiply-add, bits 26:25 set, starts during busy ignored (R8)
        step(1, r4(3'd0, 2'b11), "R7");
        step(1, r3(7'd0, 3'd0), "R8");
        step(1, r3(7'd0, 3'd0), "R8");
        step(1, r4(3'd0, 2'b00), "R7");
        idle(1, "R7");
        step(0, 32'd0, "R7");
        // R6: reserved command setting in variant A hangs
        set_cmd(4'b0011, "R6");
        step(1, R5A, "R6");
        for (int i = 0; i < TMO; i++) step(1, r3(7'd0, 3'd0), "R8");
        step(1, r3(7'd0, 3'd0), "R9");
        // R6: variant B reserved as well
        set_cmd(4'b1100, "R6");
        step(1, R5B, "R6");
        idle(TMO + 1, "R6");
        // R9: undefined codes
        step(1, r3(7'd1, 3'd0), "R9");
        idle(TMO + 1, "R9");
        step(1, r3(7'd0, 3'd5), "R9");
        idle(TMO + 1, "R9");
        step(1, r4(3'd3, 2'b00), "R9");
        idle(TMO + 1, "R9");
        step(1, {25'd0, 7'b0110011}, "R9");
        idle(TMO + 1, "R9");
        step(1, r3(7'd0, 3'd0), "R2");
        idle(2, "R10");
        ended = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule